// File: doc/BRIEF.md
# Timer Subsystem Bus Control Unit

This block sits between a CPU register bus and a cluster of timer and I/O submodules. It holds one 16-bit configuration word and turns it into three controls for the submodule side: a freeze line, a one-cycle submodule reset, and a privilege flag that guards the low part of the submodule address range.

Freeze comes from two independent bits. The halt bit freezes the submodules unconditionally. The debug-gate bit freezes them only while the global debug-freeze input is high. The reset bit is a write-one command that produces a single pulse and never reads back as set.

The privilege bit decides whether addresses `0x000`–`0x7FF` may be reached only in supervisor mode. A user-mode access to that window while the bit is set is blocked. The block raises an error for one cycle, drops the write and returns zero on a read. All CPU accesses keep working while the submodules are frozen.

Top module: `iobus_ctrl`

## Requirements
- R1: After reset, `sub_freeze`, `sub_reset`, `acc_err`, `win_priv` and `reg_rdata` are 0, and reading the configuration word returns 0.
- R2: While the halt bit (bit 15 of the configuration word) is 1, `sub_freeze` is 1 one cycle later, whatever the value of `dbg_freeze`.
- R3: While the halt bit is 0 and the debug-gate bit (bit 13) is 1, `sub_freeze` equals `dbg_freeze` delayed by one cycle. With both bits 0, `sub_freeze` is 0.
- R4: While `sub_freeze` is 1, window accesses still assert `sub_acc`, window reads still return `sub_rdata`, and the configuration word can still be written and read.
- R5: Writing the configuration word with bit 12 set gives a `sub_reset` pulse exactly one cycle wide in the cycle after the write. Writing it with bit 12 clear gives no pulse. Bit 12 always reads 0.
- R6: Only bits 15, 13 and 7 are stored. A read of the configuration word returns the written value masked with `0xA080`, so reserved bits ignore writes and read 0.
- R7: An access to an address at or below `0x7FF`, made while bit 7 is 1 and `reg_sup` is 0, is blocked. `sub_acc` stays 0, `acc_err` is 1 for exactly the next cycle, and the read data returned is 0.
- R8: A window access that is not blocked asserts `sub_acc` in the same cycle and returns `sub_rdata` on a read, with no error. `win_priv` shows bit 7.
- R9: A read of an address above `0x7FF` other than `CFG_ADDR` returns 0 and raises no error. `reg_rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| reg_addr | input | ADDR_W | CPU access address |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe |
| reg_wdata | input | 16 | CPU write data (bit 15 is the configuration word's first bit) |
| reg_sup | input | 1 | CPU is in supervisor mode |
| reg_rdata | output | 16 | Registered read data |
| acc_err | output | 1 | Privilege violation, one cycle after the access |
| dbg_freeze | input | 1 | Global debug freeze request |
| sub_rdata | input | 16 | Read data from the submodule window |
| sub_acc | output | 1 | Qualified access strobe to the submodule window |
| sub_freeze | output | 1 | Freeze line to the submodules |
| sub_reset | output | 1 | One-cycle submodule reset |
| win_priv | output | 1 | Window requires supervisor access |

## Verification
`sub_acc` is combinational, so the bench samples it in the access cycle itself, before the clock edge. `reg_rdata`, `acc_err` and `sub_reset` come from a single register stage, so they are checked at the falling edge right after the access edge. A new configuration value only reaches `sub_freeze` one edge after the value is stored, so freeze is always checked after one further cycle. The same holds for a change on `dbg_freeze`. The bench also checks in that following cycle that the reset pulse and the error have already dropped.

// File: rtl/iobus_ctrl.sv
module iobus_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'hC00,
  parameter logic [ADDR_W-1:0] WIN_TOP  = 12'h7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_sup,
  output logic [15:0]       reg_rdata,
  output logic              acc_err,
  input  logic              dbg_freeze,
  input  logic [15:0]       sub_rdata,
  output logic              sub_acc,
  output logic              sub_freeze,
  output logic              sub_reset,
  output logic              win_priv
);
  localparam int HALT_B = 15;
  localparam int GATE_B = 13;
  localparam int KICK_B = 12;
  localparam int PRIV_B = 7;

  logic halt_q, gate_q, priv_q, kick_q, frz_q, err_q;
  logic [15:0] rd_q;

  wire any_acc = reg_wr | reg_rd;
  wire in_win  = reg_addr <= WIN_TOP;
  wire cfg_hit = reg_addr == CFG_ADDR;
  wire blocked = any_acc & in_win & priv_q & ~reg_sup;
  wire cfg_wr  = reg_wr & cfg_hit;

  logic [15:0] cfg_view;
  always_comb begin
    cfg_view = '0;
    cfg_view[HALT_B] = halt_q;
    cfg_view[GATE_B] = gate_q;
    cfg_view[PRIV_B] = priv_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      gate_q <= 1'b0;
      priv_q <= 1'b0;
      kick_q <= 1'b0;
      frz_q  <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (cfg_wr) begin
        halt_q <= reg_wdata[HALT_B];
        gate_q <= reg_wdata[GATE_B];
        priv_q <= reg_wdata[PRIV_B];
      end
      kick_q <= cfg_wr & reg_wdata[KICK_B];
      frz_q  <= halt_q | (gate_q & dbg_freeze);
      err_q  <= blocked;
      if (!reg_rd)       rd_q <= '0;
      else if (cfg_hit)  rd_q <= cfg_view;
      else if (in_win && !blocked) rd_q <= sub_rdata;
      else               rd_q <= '0;
    end
  end

  assign sub_acc    = any_acc & in_win & ~blocked;
  assign reg_rdata  = rd_q;
  assign acc_err    = err_q;
  assign sub_freeze = frz_q;
  assign sub_reset  = kick_q;
  assign win_priv   = priv_q;
endmodule

// File: rtl/iobus_ctrl_chk.sv
module iobus_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'hC00,
  parameter logic [ADDR_W-1:0] WIN_TOP  = 12'h7FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [15:0]       reg_wdata,
  input logic              reg_sup,
  input logic [15:0]       reg_rdata,
  input logic              acc_err,
  input logic              dbg_freeze,
  input logic              sub_acc,
  input logic              sub_freeze,
  input logic              sub_reset,
  input logic              win_priv,
  input logic              halt_q,
  input logic              gate_q
);
  wire viol   = (reg_wr | reg_rd) && (reg_addr <= WIN_TOP) && win_priv && !reg_sup;
  wire kick_w = reg_wr && (reg_addr == CFG_ADDR) && reg_wdata[12];

  p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> sub_freeze);
  p_gate_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && gate_q) |=> (sub_freeze == $past(dbg_freeze)));
  p_no_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !gate_q) |=> !sub_freeze);
  p_kick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_w |=> sub_reset);
  p_kick_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reset |-> $past(kick_w));
  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CFG_ADDR) |=> ((reg_rdata & 16'h5F7F) == 16'h0000));
  p_block_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (acc_err && reg_rdata == 16'h0000));
  p_block_noacc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !sub_acc);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(viol));
endmodule

bind iobus_ctrl iobus_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .WIN_TOP(WIN_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_sup(reg_sup), .reg_rdata(reg_rdata), .acc_err(acc_err),
  .dbg_freeze(dbg_freeze), .sub_acc(sub_acc), .sub_freeze(sub_freeze),
  .sub_reset(sub_reset), .win_priv(win_priv), .halt_q(halt_q), .gate_q(gate_q)
);

// File: tb/test_iobus_ctrl.sv
module test_iobus_ctrl;
  localparam logic [11:0] CFG = 12'hC00;

  logic clk = 0, rst_n = 0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, reg_sup = 0, dbg_freeze = 0;
  logic [15:0] reg_wdata = '0, sub_rdata;
  logic [15:0] reg_rdata;
  logic acc_err, sub_acc, sub_freeze, sub_reset, win_priv;
  logic acc_seen;
  int vecs = 0, bad = 0;

  always #4 clk = ~clk;
  assign sub_rdata = 16'hBEEF ^ {4'h0, reg_addr};

  iobus_ctrl i_iobus_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_sup(reg_sup), .reg_rdata(reg_rdata), .acc_err(acc_err),
    .dbg_freeze(dbg_freeze), .sub_rdata(sub_rdata), .sub_acc(sub_acc),
    .sub_freeze(sub_freeze), .sub_reset(sub_reset), .win_priv(win_priv)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge; registered results are visible on return
  task automatic access(input logic [11:0] a, input logic w, input logic r,
                        input logic [15:0] d, input logic s);
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; reg_sup = s;
    #1 acc_seen = sub_acc;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] exp_rd;
    logic blk, inwin;
    logic [11:0] addrs [5];
    addrs[0] = 12'h000; addrs[1] = 12'h3A5; addrs[2] = 12'h7FF;
    addrs[3] = 12'h800; addrs[4] = 12'hFFF;

    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R1 reset state
    check("R1 freeze", {15'b0, sub_freeze}, 16'h0);
    check("R1 reset", {15'b0, sub_reset}, 16'h0);
    check("R1 err", {15'b0, acc_err}, 16'h0);
    check("R1 priv", {15'b0, win_priv}, 16'h0);
    check("R1 rdata", reg_rdata, 16'h0);
    access(CFG, 0, 1, 16'h0, 1);
    check("R1 cfg read", reg_rdata, 16'h0);

    // R5 R6 R2 R3 pattern sweep
    for (int i = 0; i < 48; i++) begin
      if (i < 16) w = 16'h1 << i;
      else if (i < 32) w = {(i[3]), 1'b1, (i[2]), (i[1]), 4'hF, (i[0]), 7'h7F};
      else w = 16'hFFFF ^ (16'h1 << (i - 32));
      dbg_freeze = i[0] ^ i[4];
      access(CFG, 1, 0, w, i[1]);
      check("R5 pulse", {15'b0, sub_reset}, {15'b0, w[12]});
      access(CFG, 0, 1, 16'h0, 0);
      check("R6 readback", reg_rdata, w & 16'hA080);
      check("R5 one wide", {15'b0, sub_reset}, 16'h0);
      check("R8 priv flag", {15'b0, win_priv}, {15'b0, w[7]});
      check("R2 R3 freeze", {15'b0, sub_freeze}, {15'b0, w[15] | (w[13] & dbg_freeze)});
    end

    // R2 R3 freeze vs debug input
    for (int c = 0; c < 8; c++) begin
      access(CFG, 1, 0, {c[2], 1'b0, c[1], 13'h0}, 1);
      dbg_freeze = c[0];
      idle();
      idle();
      check(c[2] ? "R2 halt" : "R3 gate", {15'b0, sub_freeze}, {15'b0, c[2] | (c[1] & c[0])});
      dbg_freeze = ~c[0];
      idle();
      idle();
      check(c[2] ? "R2 halt dbg" : "R3 gate dbg", {15'b0, sub_freeze}, {15'b0, c[2] | (c[1] & ~c[0])});
    end

    // R4 access while frozen
    access(CFG, 1, 0, 16'h8000, 0);
    idle();
    idle();
    check("R4 frozen", {15'b0, sub_freeze}, 16'h1);
    access(12'h123, 0, 1, 16'h0, 0);
    check("R4 sub_acc", {15'b0, acc_seen}, 16'h1);
    check("R4 window read", reg_rdata, 16'hBEEF ^ 16'h0123);
    access(12'h456, 1, 0, 16'h1234, 0);
    check("R4 window write", {15'b0, acc_seen}, 16'h1);
    access(CFG, 1, 0, 16'h2080, 0);
    access(CFG, 0, 1, 16'h0, 0);
    check("R4 cfg rw", reg_rdata, 16'h2080);

    // R7 R8 R9 privilege sweep
    dbg_freeze = 0;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 5; k++)
          for (int op = 0; op < 2; op++) begin
            access(CFG, 1, 0, p[0] ? 16'h0080 : 16'h0000, 1);
            inwin = addrs[k] <= 12'h7FF;
            blk = inwin & p[0] & ~s[0];
            access(addrs[k], op[0], ~op[0], 16'h5A5A, s[0]);
            check(blk ? "R7 no access" : "R8 access", {15'b0, acc_seen}, {15'b0, inwin & ~blk});
            check(blk ? "R7 error" : "R8 R9 no error", {15'b0, acc_err}, {15'b0, blk});
            exp_rd = (!op[0] && inwin && !blk) ? (16'hBEEF ^ {4'h0, addrs[k]}) : 16'h0;
            check(blk ? "R7 read zero" : "R8 R9 read", reg_rdata, exp_rd);
            idle();
            check("R7 error one cycle", {15'b0, acc_err}, 16'h0);
            check("R9 idle rdata", reg_rdata, 16'h0);
          end
    access(CFG, 0, 1, 16'h0, 0);
    check("R6 cfg unchanged by window", reg_rdata, 16'h0080);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule